// File: doc/BRIEF.md
# CAN Interrupt Identifier

This block merges the interrupt sources of a CAN controller into one 16-bit identifier register and one interrupt request line to the CPU. There are two kinds of source. The first is a status source, which the protocol core raises when it updates its status register. The second is a bank of per-message-object pending flags. The status source always wins and reports a fixed code. Otherwise the identifier names the lowest-numbered message object that has its pending flag set. When nothing is pending, the identifier is zero.

The status source is armed by an update strobe from the core. An error update is gated by the error-interrupt enable, and any other update is gated by the status-interrupt enable. Only a read of the status register disarms it. The identifier is recomputed every clock, including while the global interrupt enable is off. The global enable only gates the request line. Interrupt service software either follows the identifier or clears pending flags, and the identifier then moves on to the next source.

Top module: `can_irq_ident`

## Requirements
- R1: While reset is asserted, `int_id` is 0 and `irq` is 0.
- R2: With no message flag set and the status source idle, `int_id` is 0 after the next rising clock edge.
- R3: While the status source is pending, `int_id` is 16'h8000 regardless of the message flags.
- R4: With the status source idle, `int_id` equals i+1 one clock after sampling, where bit i of `msg_pend` is the lowest set bit. Bit 0 is object 1 and has the highest priority.
- R5: When the flag of the reported object is cleared, `int_id` moves on the next edge to the next set flag in priority order, and to 0 when none remains.
- R6: A `stat_upd` pulse with `stat_err`=1 arms the status source only if `err_ie`=1. With `stat_err`=0, it arms the source only if `stat_ie`=1. The effect appears in `int_id` one clock later.
- R7: A `stat_rd` pulse without an enabled update disarms the status source. `int_id` falls back to the message result on the next edge.
- R8: If an enabled update and `stat_rd` fall in the same cycle, the status source stays pending.
- R9: `irq` is high exactly when `irq_en`=1 and `int_id` is nonzero. Clearing `irq_en` drops `irq` without waiting for a clock.
- R10: `int_id` keeps following the sources while `irq_en`=0.
- R11: No input other than an enabled update or a read changes the status source. Message flags and enable changes leave a pending status in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_upd | input | 1 | Status-register update strobe from the protocol core |
| stat_err | input | 1 | Qualifies `stat_upd` as an error update |
| err_ie | input | 1 | Error-interrupt enable |
| stat_ie | input | 1 | Status-interrupt enable |
| irq_en | input | 1 | Global interrupt-line enable |
| msg_pend | input | NUM_OBJ | Message-object pending flags, bit i = object i+1 |
| stat_rd | input | 1 | Status-register read strobe |
| int_id | output | 16 | Interrupt identifier |
| irq | output | 1 | Interrupt request line |

## Verification
The encoder is driven with several flag patterns:
- a single flag at each end of the vector, which exposes off-by-one numbering and reversed priority;
- sparse multi-bit and all-ones vectors, which separate lowest-first from highest-first selection;
- a flag set that is cleared one flag at a time, which checks that the identifier moves on in order.

The status source is exercised under each pairing of update type and enable, which shows whether each enable gates the right update type. It is also exercised with a read, with a read in the same cycle as an update, and with a read in the same cycle as a disabled update, which tells the precedence rule apart from simple clearing. Toggling the global enable while the flags change shows whether the line is gated and the identifier still tracks.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned ID_W = 16;
  typedef logic [ID_W-1:0] irq_id_t;
  localparam irq_id_t STATUS_CODE = 16'h8000;
endpackage

// File: rtl/can_irq_rst_sync.sv
module can_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/can_irq_stat_src.sv
module can_irq_stat_src (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_upd,
  input  logic stat_err,
  input  logic err_ie,
  input  logic stat_ie,
  input  logic stat_rd,
  output logic pend_d,
  output logic pend_q
);
  logic arm;
  logic upd_en;

  // Error updates follow err_ie, other updates follow stat_ie.
  always_comb begin
    arm    = stat_upd & (stat_err ? err_ie : stat_ie);
    upd_en = arm | stat_rd;
    // Arming has precedence over a read in the same cycle.
    if (arm)          pend_d = 1'b1;
    else if (stat_rd) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (upd_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/can_irq_prio_enc.sv
module can_irq_prio_enc #(
  parameter int unsigned NUM_OBJ = 32,
  localparam int unsigned IDX_W = $clog2(NUM_OBJ + 1)
) (
  input  logic [NUM_OBJ-1:0] pend,
  output logic [IDX_W-1:0]   obj_num
);
  logic [NUM_OBJ-1:0] lower_any;
  logic [NUM_OBJ-1:0] win;

  assign lower_any[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < NUM_OBJ; gi++) begin : g_chain
      assign lower_any[gi] = lower_any[gi-1] | pend[gi-1];
    end
    for (gi = 0; gi < NUM_OBJ; gi++) begin : g_win
      assign win[gi] = pend[gi] & ~lower_any[gi];
    end
  endgenerate

  // The win vector is one-hot or empty, so OR-merging the numbers is exact.
  always_comb begin
    obj_num = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (win[i]) obj_num = obj_num | IDX_W'(i + 1);
    end
  end
endmodule

// File: rtl/can_irq_ident.sv
module can_irq_ident
  import can_irq_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  localparam int unsigned IDX_W = $clog2(NUM_OBJ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_upd,
  input  logic               stat_err,
  input  logic               err_ie,
  input  logic               stat_ie,
  input  logic               irq_en,
  input  logic [NUM_OBJ-1:0] msg_pend,
  input  logic               stat_rd,
  output logic [ID_W-1:0]    int_id,
  output logic               irq
);
  logic            rst_sync_n;
  logic            stat_pend_d;
  logic            stat_pend_q;
  logic [IDX_W-1:0] obj_num;
  irq_id_t         id_d;
  irq_id_t         id_q;
  logic            id_en;

  can_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  can_irq_stat_src u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stat_upd (stat_upd),
    .stat_err (stat_err),
    .err_ie   (err_ie),
    .stat_ie  (stat_ie),
    .stat_rd  (stat_rd),
    .pend_d   (stat_pend_d),
    .pend_q   (stat_pend_q)
  );

  can_irq_prio_enc #(.NUM_OBJ(NUM_OBJ)) u_enc (
    .pend    (msg_pend),
    .obj_num (obj_num)
  );

  // The identifier tracks its sources every cycle, whatever irq_en is.
  always_comb begin
    id_en = 1'b1;
    if (stat_pend_d) id_d = STATUS_CODE;
    else             id_d = irq_id_t'(obj_num);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) id_q <= '0;
    else if (id_en)  id_q <= id_d;
  end

  assign int_id = id_q;
  assign irq    = irq_en & (|id_q);

  logic unused_q;
  assign unused_q = stat_pend_q;
endmodule

// File: rtl/can_irq_ident_chk.sv
module can_irq_ident_chk
  import can_irq_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  localparam int unsigned IDX_W = $clog2(NUM_OBJ + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stat_upd,
  input logic               stat_err,
  input logic               err_ie,
  input logic               stat_ie,
  input logic               irq_en,
  input logic [NUM_OBJ-1:0] msg_pend,
  input logic               stat_rd,
  input logic [ID_W-1:0]    int_id,
  input logic               irq
);
  logic [NUM_OBJ-1:0] pend_q;
  logic               vld_q;
  logic               sel_ok;
  logic               low_ok;
  logic               armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= msg_pend;
      vld_q  <= 1'b1;
    end
  end

  assign armed = stat_upd & (stat_err ? err_ie : stat_ie);

  always_comb begin
    sel_ok = 1'b0;
    low_ok = (int_id[ID_W-1:IDX_W] == '0);
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (IDX_W'(i + 1) == int_id[IDX_W-1:0])     sel_ok = pend_q[i];
      else if (IDX_W'(i + 1) < int_id[IDX_W-1:0]) begin
        if (pend_q[i]) low_ok = 1'b0;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (int_id == '0 && !irq));

  p_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pend == '0 && int_id != STATUS_CODE && !stat_upd) |=> int_id == '0);

  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && int_id != '0 && int_id != STATUS_CODE) |-> (sel_ok && low_ok));

  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> int_id == STATUS_CODE);

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !armed && msg_pend == '0) |=> int_id == '0);

  p_upd_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stat_rd) |=> int_id == STATUS_CODE);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id == STATUS_CODE && !stat_rd) |=> int_id == STATUS_CODE);
endmodule

bind can_irq_ident can_irq_ident_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .stat_upd (stat_upd),
  .stat_err (stat_err),
  .err_ie   (err_ie),
  .stat_ie  (stat_ie),
  .irq_en   (irq_en),
  .msg_pend (msg_pend),
  .stat_rd  (stat_rd),
  .int_id   (int_id),
  .irq      (irq)
);

// File: tb/can_irq_ident_tb.sv
module can_irq_ident_tb;
  localparam int unsigned N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stat_upd, stat_err, err_ie, stat_ie, irq_en, stat_rd;
  logic [N-1:0]  msg_pend;
  logic [15:0]   int_id;
  logic          irq;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  can_irq_ident #(.NUM_OBJ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .stat_upd(stat_upd), .stat_err(stat_err),
    .err_ie(err_ie), .stat_ie(stat_ie), .irq_en(irq_en), .msg_pend(msg_pend),
    .stat_rd(stat_rd), .int_id(int_id), .irq(irq)
  );

  function automatic logic [15:0] model_id(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 16'(i + 1);
    return 16'h0;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_upd(logic err, logic rd);
    stat_upd = 1'b1; stat_err = err; stat_rd = rd;
    step();
    stat_upd = 1'b0; stat_err = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stat_upd = 0; stat_err = 0; err_ie = 1; stat_ie = 1;
    irq_en = 1; stat_rd = 0; msg_pend = 32'h0000_0005;
    repeat (3) step();
    chk("R1 id in reset", int_id, 16'h0);
    chk("R1 irq in reset", {15'h0, irq}, 16'h0);
    msg_pend = '0;
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_empty();
    msg_pend = '0; irq_en = 1;
    step();
    chk("R2 empty id", int_id, 16'h0);
    chk("R9 empty irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_priority();
    logic [N-1:0] pats [5];
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'h0001_0100;
    pats[3] = 32'hA000_0000; pats[4] = 32'hFFFF_FFFF;
    for (int k = 0; k < 5; k++) begin
      msg_pend = pats[k];
      step();
      chk("R4 priority id", int_id, model_id(pats[k]));
      chk("R9 irq with pending", {15'h0, irq}, 16'h1);
    end
  endtask

  task automatic t_walk();
    msg_pend = (32'h1 << 2) | (32'h1 << 5) | (32'h1 << 17);
    step(); chk("R5 walk start", int_id, 16'd3);
    msg_pend[2] = 1'b0;
    step(); chk("R5 walk next", int_id, 16'd6);
    msg_pend[5] = 1'b0;
    step(); chk("R5 walk last", int_id, 16'd18);
    msg_pend[17] = 1'b0;
    step(); chk("R5 walk empty", int_id, 16'h0);
  endtask

  task automatic t_status_read();
    msg_pend = 32'h0000_0010; err_ie = 1; stat_ie = 0;
    step();
    pulse_upd(1'b1, 1'b0);
    chk("R3 status over message", int_id, 16'h8000);
    msg_pend = 32'h0000_0001; err_ie = 0; stat_ie = 1;
    step(); step();
    chk("R11 status holds", int_id, 16'h8000);
    pulse_rd();
    chk("R7 read clears", int_id, 16'd1);
    msg_pend = '0;
    step();
  endtask

  task automatic t_enables();
    err_ie = 0; stat_ie = 1; pulse_upd(1'b1, 1'b0);
    chk("R6 error update blocked", int_id, 16'h0);
    err_ie = 1; stat_ie = 0; pulse_upd(1'b0, 1'b0);
    chk("R6 status update blocked", int_id, 16'h0);
    err_ie = 0; stat_ie = 1; pulse_upd(1'b0, 1'b0);
    chk("R6 status update armed", int_id, 16'h8000);
    pulse_rd();
    chk("R7 read clears to empty", int_id, 16'h0);
    err_ie = 1; stat_ie = 0; pulse_upd(1'b1, 1'b0);
    chk("R6 error update armed", int_id, 16'h8000);
    pulse_rd();
  endtask

  task automatic t_same_cycle();
    err_ie = 1; stat_ie = 1; msg_pend = 32'h0000_0004;
    pulse_upd(1'b0, 1'b0);
    pulse_upd(1'b1, 1'b1);
    chk("R8 update wins over read", int_id, 16'h8000);
    err_ie = 0;
    pulse_upd(1'b1, 1'b1);
    chk("R7 read with disabled update", int_id, 16'd3);
    msg_pend = '0;
    step();
  endtask

  task automatic t_gate();
    irq_en = 0; msg_pend = 32'h0000_0040;
    step();
    chk("R10 id tracks with line off", int_id, 16'd7);
    chk("R9 line off", {15'h0, irq}, 16'h0);
    msg_pend = 32'h0000_0400;
    step();
    chk("R10 id follows change", int_id, 16'd11);
    irq_en = 1; #1;
    chk("R9 line on", {15'h0, irq}, 16'h1);
    irq_en = 0; #1;
    chk("R9 line drops on enable clear", {15'h0, irq}, 16'h0);
    irq_en = 1;
    msg_pend = '0;
    step();
    chk("R9 line drops with id zero", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    t_reset();
    t_empty();
    t_priority();
    t_walk();
    t_status_read();
    t_enables();
    t_same_cycle();
    t_gate();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule